// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block resolves a translation miss by fetching descriptors from a two-level table held in ordinary memory. A walk starts from a virtual address and the current table base. The walker reads one first-level word. When that word is a leaf (a 1 MB section or a 16 MB supersection), the walk ends there. When it points to a coarse second-level table, one more word is fetched, which describes either a 4 KB small page or a 64 KB large page. The block returns the translated physical address, a page-size code and the three mapping attributes (endianness, element size, mixed-size), ready to be written into a TLB entry.

Memory is reached through a plain read port that carries one 32-bit word for each request. Walks arrive on a valid/ready port. `walk_ready` is high only while the walker is idle, and `walk_va` and `tbl_base` are sampled on the handshake. The read request `rd_valid` stays high, with `rd_addr` unchanged, until `rd_ready` is seen high at a clock edge. The response (`rd_rsp_valid`/`rd_rsp_data`) has no ready signal and must only arrive for a request that is outstanding. The result appears as a single-cycle `done` pulse with no back-pressure.

A walk that meets an invalid descriptor ends with `done_fault`. The first faulting virtual address is kept in a holding register until software acknowledges it.

Top module: `pw_walker`

## Requirements
- R1: After reset, `walk_ready` is 1, and `rd_valid`, `done` and `flt_pending` are 0.
- R2: The first read address is {tbl_base[31:14], va[31:20], 2'b00}. The low 14 bits of `tbl_base` have no effect.
- R3: A first-level word with bits [1:0]=2 and bit 18 clear is a section. The walk reads exactly one word and returns size code 2 with PA = {d[31:20], va[19:0]}. Endianness comes from bit 15, element size from bits 11:10 and mixed-size from bit 17.
- R4: A first-level word with bits [1:0]=2 and bit 18 set is a supersection. The walk returns size code 3 with PA = {d[31:24], va[23:0]}. Bits 23:19 of the descriptor are ignored. The attributes come from the same bits as in R3.
- R5: A first-level word with bits [1:0]=1 is a coarse pointer. A second read follows at {d[31:10], va[19:12], 2'b00}, and the walk performs exactly two reads.
- R6: A second-level word with bits [1:0]=2 is a small page. The walk returns size code 0 with PA = {d[31:12], va[11:0]}. Endianness comes from bit 9, element size from bits 5:4 and mixed-size from bit 11.
- R7: A second-level word with bits [1:0]=1 is a large page. The walk returns size code 1 with PA = {d[31:16], va[15:0]}. Bits 15:12 are ignored, so each of the 16 replicated slots of one large page gives the same base and attributes.
- R8: Bits [1:0] equal to 0 or 3, at either level, end the walk with `done_fault`=1. In that case `done_pa`, `done_size` and all attributes are 0.
- R9: A faulting walk sets `flt_pending` and loads `flt_va` in the cycle after `done`. Later faults leave `flt_va` unchanged while the flag is pending. `flt_ack` clears the flag. An ack that falls in the same cycle as a fault's `done` captures the new address, and the flag stays set.
- R10: Only one walk is in flight at a time, and `walk_ready` is 0 from acceptance until `done`. `done` lasts exactly one cycle.
- R11: The read request keeps `rd_valid` and `rd_addr` stable until `rd_ready` is sampled high. Stalls of the request and variable response latency do not change any result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_base | input | 32 | Table base; only bits 31:14 are used |
| walk_valid | input | 1 | Walk request valid |
| walk_ready | output | 1 | Walker idle, request accepted |
| walk_va | input | 32 | Virtual address to translate |
| rd_valid | output | 1 | Memory read request valid |
| rd_ready | input | 1 | Memory accepts the read request |
| rd_addr | output | 32 | Byte address of the descriptor word |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_data | input | 32 | Descriptor word |
| done | output | 1 | One-cycle walk completion pulse |
| done_fault | output | 1 | Walk hit an invalid descriptor |
| done_pa | output | 32 | Translated physical address |
| done_size | output | 2 | 0=4 KB, 1=64 KB, 2=1 MB, 3=16 MB |
| done_big_endian | output | 1 | Endianness attribute |
| done_elem_size | output | 2 | Element-size attribute |
| done_mixed | output | 1 | Mixed-size attribute |
| flt_pending | output | 1 | A fault address is held |
| flt_va | output | 32 | Held faulting virtual address |
| flt_ack | input | 1 | Acknowledge and release the held fault |

## Verification
A fault acknowledge and the completion of a new faulting walk can land on the same clock edge. The holding register then has to release the old address and capture the new one together. The bench provokes this by raising `flt_ack` in the very cycle in which it sees `done` with `done_fault`. One cycle later it expects `flt_pending` still set and `flt_va` equal to the second walk's address. A separate pass shows that a bare ack clears the flag and that an unacknowledged second fault leaves the first address in place.

// File: rtl/pw_pkg.sv
package pw_pkg;
  localparam int AW         = 32;
  localparam int TBL_ALIGN  = 14;
  localparam int L1_SHIFT   = 20;
  localparam int L1_IDX_W   = AW - L1_SHIFT;
  localparam int PG_SHIFT   = 12;
  localparam int L2_IDX_W   = L1_SHIFT - PG_SHIFT;
  localparam int CRS_SHIFT  = 10;
  localparam int LRG_SHIFT  = 16;
  localparam int SUP_SHIFT  = 24;
  localparam int SUP_BIT    = 18;

  typedef enum logic [1:0] {
    PG_4K  = 2'd0,
    PG_64K = 2'd1,
    PG_1M  = 2'd2,
    PG_16M = 2'd3
  } pg_size_e;

  typedef struct packed {
    logic       big_endian;
    logic [1:0] elem_size;
    logic       mixed;
  } pg_attr_t;

  typedef enum logic [2:0] {
    S_IDLE    = 3'd0,
    S_L1_REQ  = 3'd1,
    S_L1_WAIT = 3'd2,
    S_L2_REQ  = 3'd3,
    S_L2_WAIT = 3'd4,
    S_DONE    = 3'd5
  } walk_st_e;
endpackage

// File: rtl/pw_l1_decode.sv
module pw_l1_decode
  import pw_pkg::*;
(
  input  logic [AW-1:0] desc,
  input  logic [AW-1:0] va,
  output logic          fault,
  output logic          next_lvl,
  output logic [AW-1:0] l2_addr,
  output pg_size_e      size,
  output logic [AW-1:0] pa,
  output pg_attr_t      attr
);
  always_comb begin
    fault    = 1'b0;
    next_lvl = 1'b0;
    l2_addr  = '0;
    size     = PG_4K;
    pa       = '0;
    attr     = '0;
    unique case (desc[1:0])
      2'b10: begin
        attr = '{big_endian: desc[15], elem_size: desc[11:10], mixed: desc[17]};
        if (desc[SUP_BIT]) begin
          size = PG_16M;
          pa   = {desc[AW-1:SUP_SHIFT], va[SUP_SHIFT-1:0]};
        end else begin
          size = PG_1M;
          pa   = {desc[AW-1:L1_SHIFT], va[L1_SHIFT-1:0]};
        end
      end
      2'b01: begin
        next_lvl = 1'b1;
        l2_addr  = {desc[AW-1:CRS_SHIFT], va[L1_SHIFT-1:PG_SHIFT], 2'b00};
      end
      default: fault = 1'b1;
    endcase
  end
endmodule

// File: rtl/pw_l2_decode.sv
module pw_l2_decode
  import pw_pkg::*;
(
  input  logic [AW-1:0] desc,
  input  logic [AW-1:0] va,
  output logic          fault,
  output pg_size_e      size,
  output logic [AW-1:0] pa,
  output pg_attr_t      attr
);
  always_comb begin
    fault = 1'b0;
    size  = PG_4K;
    pa    = '0;
    attr  = '0;
    unique case (desc[1:0])
      2'b10: begin
        size = PG_4K;
        pa   = {desc[AW-1:PG_SHIFT], va[PG_SHIFT-1:0]};
        attr = '{big_endian: desc[9], elem_size: desc[5:4], mixed: desc[11]};
      end
      2'b01: begin
        size = PG_64K;
        pa   = {desc[AW-1:LRG_SHIFT], va[LRG_SHIFT-1:0]};
        attr = '{big_endian: desc[9], elem_size: desc[5:4], mixed: desc[11]};
      end
      default: fault = 1'b1;
    endcase
  end
endmodule

// File: rtl/pw_fault_hold.sv
module pw_fault_hold
  import pw_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture,
  input  logic [AW-1:0] va_in,
  input  logic          ack,
  output logic          pending,
  output logic [AW-1:0] va_out
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0;
      va_out  <= '0;
    end else if (capture && (!pending || ack)) begin
      pending <= 1'b1;
      va_out  <= va_in;
    end else if (ack) begin
      pending <= 1'b0;
    end
  end
endmodule

// File: rtl/pw_walker.sv
module pw_walker
  import pw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] tbl_base,
  input  logic        walk_valid,
  output logic        walk_ready,
  input  logic [31:0] walk_va,
  output logic        rd_valid,
  input  logic        rd_ready,
  output logic [31:0] rd_addr,
  input  logic        rd_rsp_valid,
  input  logic [31:0] rd_rsp_data,
  output logic        done,
  output logic        done_fault,
  output logic [31:0] done_pa,
  output logic [1:0]  done_size,
  output logic        done_big_endian,
  output logic [1:0]  done_elem_size,
  output logic        done_mixed,
  output logic        flt_pending,
  output logic [31:0] flt_va,
  input  logic        flt_ack
);
  walk_st_e      st_q;
  logic [AW-1:0] va_q;
  logic [AW-1:0] addr_q;
  logic          res_fault_q;
  logic [AW-1:0] res_pa_q;
  pg_size_e      res_size_q;
  pg_attr_t      res_attr_q;

  logic          l1_fault, l1_next;
  logic [AW-1:0] l1_l2addr, l1_pa;
  pg_size_e      l1_size;
  pg_attr_t      l1_attr;
  logic          l2_fault;
  logic [AW-1:0] l2_pa;
  pg_size_e      l2_size;
  pg_attr_t      l2_attr;

  pw_l1_decode u_l1 (
    .desc(rd_rsp_data), .va(va_q), .fault(l1_fault), .next_lvl(l1_next),
    .l2_addr(l1_l2addr), .size(l1_size), .pa(l1_pa), .attr(l1_attr)
  );

  pw_l2_decode u_l2 (
    .desc(rd_rsp_data), .va(va_q), .fault(l2_fault),
    .size(l2_size), .pa(l2_pa), .attr(l2_attr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= S_IDLE;
      va_q        <= '0;
      addr_q      <= '0;
      res_fault_q <= 1'b0;
      res_pa_q    <= '0;
      res_size_q  <= PG_4K;
      res_attr_q  <= '0;
    end else begin
      unique case (st_q)
        S_IDLE: if (walk_valid) begin
          va_q   <= walk_va;
          addr_q <= {tbl_base[AW-1:TBL_ALIGN], walk_va[AW-1:L1_SHIFT], 2'b00};
          st_q   <= S_L1_REQ;
        end
        S_L1_REQ: if (rd_ready) st_q <= S_L1_WAIT;
        S_L1_WAIT: if (rd_rsp_valid) begin
          if (l1_next) begin
            addr_q <= l1_l2addr;
            st_q   <= S_L2_REQ;
          end else begin
            res_fault_q <= l1_fault;
            res_pa_q    <= l1_pa;
            res_size_q  <= l1_size;
            res_attr_q  <= l1_attr;
            st_q        <= S_DONE;
          end
        end
        S_L2_REQ: if (rd_ready) st_q <= S_L2_WAIT;
        S_L2_WAIT: if (rd_rsp_valid) begin
          res_fault_q <= l2_fault;
          res_pa_q    <= l2_pa;
          res_size_q  <= l2_size;
          res_attr_q  <= l2_attr;
          st_q        <= S_DONE;
        end
        S_DONE:  st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign walk_ready      = (st_q == S_IDLE);
  assign rd_valid        = (st_q == S_L1_REQ) || (st_q == S_L2_REQ);
  assign rd_addr         = addr_q;
  assign done            = (st_q == S_DONE);
  assign done_fault      = res_fault_q;
  assign done_pa         = res_pa_q;
  assign done_size       = res_size_q;
  assign done_big_endian = res_attr_q.big_endian;
  assign done_elem_size  = res_attr_q.elem_size;
  assign done_mixed      = res_attr_q.mixed;

  pw_fault_hold u_flt (
    .clk(clk), .rst_n(rst_n), .capture(done && res_fault_q), .va_in(va_q),
    .ack(flt_ack), .pending(flt_pending), .va_out(flt_va)
  );
endmodule

// File: rtl/pw_walker_chk.sv
module pw_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        walk_ready,
  input logic        rd_valid,
  input logic        rd_ready,
  input logic [31:0] rd_addr,
  input logic        done,
  input logic        done_fault,
  input logic [31:0] done_pa,
  input logic [1:0]  done_size,
  input logic        done_big_endian,
  input logic [1:0]  done_elem_size,
  input logic        done_mixed,
  input logic        flt_pending,
  input logic [31:0] flt_va,
  input logic        flt_ack
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_ONE_WALK: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !walk_ready); // R10
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr)); // R11
  AST_FAULT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    done && done_fault |-> done_pa == 32'd0 && done_size == 2'd0 &&
      !done_big_endian && done_elem_size == 2'd0 && !done_mixed); // R8
  AST_FLT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    flt_pending && !flt_ack |=> flt_pending && $stable(flt_va)); // R9
  AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    flt_ack && !(done && done_fault) |=> !flt_pending); // R9
  AST_FLT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    done && done_fault |=> flt_pending); // R9
endmodule

bind pw_walker pw_walker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .walk_ready(walk_ready), .rd_valid(rd_valid),
  .rd_ready(rd_ready), .rd_addr(rd_addr), .done(done), .done_fault(done_fault),
  .done_pa(done_pa), .done_size(done_size), .done_big_endian(done_big_endian),
  .done_elem_size(done_elem_size), .done_mixed(done_mixed),
  .flt_pending(flt_pending), .flt_va(flt_va), .flt_ack(flt_ack)
);

// File: tb/sim_pw_walker.sv
module sim_pw_walker;
  localparam int PERIOD = 10;
  localparam logic [31:0] TTB = 32'h0010_0000;
  localparam logic [31:0] CRS = 32'h0800_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] tbl_base = TTB;
  logic walk_valid = 1'b0;
  logic walk_ready;
  logic [31:0] walk_va = '0;
  logic rd_valid, rd_ready = 1'b0;
  logic [31:0] rd_addr;
  logic rd_rsp_valid = 1'b0;
  logic [31:0] rd_rsp_data = '0;
  logic done, done_fault, done_big_endian, done_mixed, flt_pending;
  logic [31:0] done_pa, flt_va;
  logic [1:0] done_size, done_elem_size;
  logic flt_ack = 1'b0;

  int errors = 0, checks = 0;
  int stall = 0, lat = 0, nreads = 0;
  logic [31:0] addr0, addr1;
  logic finished = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  pw_walker u0 (.*);

  function automatic logic [31:0] l1desc(input logic [11:0] i);
    logic [31:0] at;
    at = ({31'd0, i[0]} << 15) | ({30'd0, i[2:1]} << 10) | ({31'd0, i[3]} << 17);
    case (i % 5)
      1: l1desc = ((({20'd0, i} * 7 + 3) & 32'hFFF) << 20) | ({31'd0, i[4]} << 19) | at | 32'd2;
      2: l1desc = ((({20'd0, i} * 13) & 32'hFF) << 24) | ({28'd0, i[7:4]} << 20) | at | (32'd1 << 18) | 32'd2;
      3: l1desc = CRS | ({20'd0, i} << 10) | 32'd1;
      4: l1desc = 32'd3;
      default: l1desc = 32'd0;
    endcase
  endfunction

  function automatic logic [31:0] l2desc(input logic [11:0] i, input logic [7:0] j);
    logic [3:0] k;
    k = j[7:4];
    case (({20'd0, i} + {28'd0, k}) % 4)
      1: l2desc = ((({20'd0, i} + {28'd0, k} * 3) & 32'hFFFF) << 16) | ({28'd0, j[3:0]} << 12)
                  | ({31'd0, k[0]} << 9) | ({30'd0, k[2:1]} << 4) | ({31'd0, k[3]} << 11) | 32'd1;
      2: l2desc = ((({20'd0, i} * 31 + {24'd0, j} * 5) & 32'hFFFFF) << 12)
                  | ({31'd0, j[0]} << 9) | ({30'd0, j[2:1]} << 4) | ({31'd0, j[3]} << 11) | 32'd2;
      3: l2desc = 32'd3;
      default: l2desc = 32'd0;
    endcase
  endfunction

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    if (a[31:14] == TTB[31:14]) mem_word = l1desc(a[13:2]);
    else if (a[31:22] == CRS[31:22]) mem_word = l2desc(a[21:10], a[9:2]);
    else mem_word = 32'd0;
  endfunction

  initial begin : mem_model
    forever begin
      @(negedge clk);
      if (rd_valid) begin
        repeat (stall) @(negedge clk);
        rd_ready = 1'b1;
        if (nreads == 0) addr0 = rd_addr; else addr1 = rd_addr;
        nreads++;
        @(negedge clk);
        rd_ready = 1'b0;
        repeat (lat) @(negedge clk);
        rd_rsp_valid = 1'b1;
        rd_rsp_data = mem_word(nreads == 1 ? addr0 : addr1);
        @(negedge clk);
        rd_rsp_valid = 1'b0;
      end
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic s_fault, s_be, s_mx, s_ready;
  logic [31:0] s_pa;
  logic [1:0] s_size, s_es;

  task automatic walk(input logic [31:0] va, input logic [31:0] base, input bit ack_at_done);
    int w;
    nreads = 0;
    @(negedge clk);
    tbl_base = base; walk_va = va; walk_valid = 1'b1;
    @(negedge clk);
    walk_valid = 1'b0;
    w = 0;
    while (!done && w < 1000) begin @(negedge clk); w++; end
    if (w >= 1000) begin
      errors++; checks++;
      $display("FAIL R10 watchdog actual=no done expected=done");
    end
    s_fault = done_fault; s_pa = done_pa; s_size = done_size;
    s_be = done_big_endian; s_es = done_elem_size; s_mx = done_mixed; s_ready = walk_ready;
    if (ack_at_done) flt_ack = 1'b1;
    @(negedge clk);
    flt_ack = 1'b0;
    check("R10 done lasts one cycle", {63'd0, done}, 64'd0);
  endtask

  task automatic expect_walk(input logic [31:0] va, input logic [31:0] base);
    logic [11:0] i; logic [7:0] j; logic [3:0] k;
    logic f; logic [31:0] pa; logic [1:0] sz, es; logic be, mx; int rds;
    logic [31:0] a1;
    string tag;
    i = va[31:20]; j = va[19:12]; k = j[7:4];
    f = 0; pa = 0; sz = 0; es = 0; be = 0; mx = 0; rds = 1; a1 = 0;
    case (i % 5)
      1: begin tag = "R3"; sz = 2; pa = ((({20'd0, i} * 7 + 3) & 32'hFFF) << 20) | {12'd0, va[19:0]};
               be = i[0]; es = i[2:1]; mx = i[3]; end
      2: begin tag = "R4"; sz = 3; pa = ((({20'd0, i} * 13) & 32'hFF) << 24) | {8'd0, va[23:0]};
               be = i[0]; es = i[2:1]; mx = i[3]; end
      3: begin
        rds = 2; a1 = CRS | ({20'd0, i} << 10) | ({24'd0, j} << 2);
        case (({20'd0, i} + {28'd0, k}) % 4)
          1: begin tag = "R7"; sz = 1; pa = ((({20'd0, i} + {28'd0, k} * 3) & 32'hFFFF) << 16) | {16'd0, va[15:0]};
                   be = k[0]; es = k[2:1]; mx = k[3]; end
          2: begin tag = "R6"; sz = 0; pa = ((({20'd0, i} * 31 + {24'd0, j} * 5) & 32'hFFFFF) << 12) | {20'd0, va[11:0]};
                   be = j[0]; es = j[2:1]; mx = j[3]; end
          default: begin tag = "R8"; f = 1; end
        endcase
      end
      default: begin tag = "R8"; f = 1; end
    endcase
    walk(va, base, 1'b0);
    check({tag, " result"}, {28'd0, f, be, mx, s_size == 2'd0 ? 1'b0 : 1'b0, s_pa, sz, es},
          {28'd0, s_fault, s_be, s_mx, 1'b0, pa, s_size, s_es});
    check({tag, " size/attr"}, {58'd0, s_fault, s_be, s_mx, s_es, s_size[0]},
          {58'd0, f, be, mx, es, sz[0]});
    check({tag, " size code"}, {62'd0, s_size}, {62'd0, sz});
    check("R2 first read address", {32'd0, addr0}, {32'd0, TTB[31:14], i, 2'b00});
    check("R5 read count", 64'(nreads), 64'(rds));
    if (rds == 2) check("R5 second read address", {32'd0, addr1}, {32'd0, a1});
    check("R10 busy at done", {63'd0, s_ready}, 64'd0);
  endtask

  initial begin : watchdog
    #(PERIOD * 200000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL R10 global watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] fa, fb;
    repeat (3) @(negedge clk);
    check("R1 reset walk_ready", {63'd0, walk_ready}, 64'd1);
    check("R1 reset rd_valid", {63'd0, rd_valid}, 64'd0);
    check("R1 reset done", {63'd0, done}, 64'd0);
    check("R1 reset flt_pending", {63'd0, flt_pending}, 64'd0);
    rst_n = 1'b1;

    for (int n = 0; n < 300; n++) begin
      stall = n % 3;
      lat = (n / 2) % 3;
      expect_walk((n * 32'h00F1_3A57) ^ (n << 7), (n % 4 == 0) ? (TTB | 32'h3FFF) : TTB); // R2 R11
    end
    for (int s = 0; s < 5; s++) begin
      stall = s % 2; lat = s;
      expect_walk({12'd0 + 12'(s), 8'h5A, 12'h123}, TTB);
    end

    stall = 1; lat = 1;
    for (int j = 8'h20; j < 8'h30; j++) begin
      expect_walk({12'd3, 8'(j), 12'hABC}, TTB); // R7 replicated slots
      check("R7 replicated base", {32'd0, s_pa & 32'hFFFF_0000}, {32'd0, 32'h0009_0000});
    end

    walk(32'h0000_0000, TTB, 1'b1);
    @(negedge clk); flt_ack = 1'b1; @(negedge clk); flt_ack = 1'b0;
    check("R9 ack clears", {63'd0, flt_pending}, 64'd0);
    fa = 32'h0050_1234; fb = 32'h00A0_5678;
    walk(fa, TTB, 1'b0);
    check("R9 first fault held", {31'd0, flt_pending, flt_va}, {31'd0, 1'b1, fa});
    walk(fb, TTB, 1'b0);
    check("R9 second fault no overwrite", {31'd0, flt_pending, flt_va}, {31'd0, 1'b1, fa});
    walk(32'h0010_0000, TTB, 1'b0);
    check("R9 good walk keeps fault", {31'd0, flt_pending, flt_va}, {31'd0, 1'b1, fa});
    @(negedge clk); flt_ack = 1'b1; @(negedge clk); flt_ack = 1'b0;
    check("R9 ack releases", {63'd0, flt_pending}, 64'd0);
    walk(fa, TTB, 1'b0);
    walk(fb, TTB, 1'b1);
    check("R9 ack with new fault captures new", {31'd0, flt_pending, flt_va}, {31'd0, 1'b1, fb});
    @(negedge clk); flt_ack = 1'b1; @(negedge clk); flt_ack = 1'b0;
    check("R9 final ack", {63'd0, flt_pending}, 64'd0);
    walk(32'h0040_0000, TTB, 1'b0);
    check("R8 reserved code faults", {63'd0, s_fault}, 64'd1);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule